// File: doc/BRIEF.md
# Retriggerable Watchdog Timer with Sticky Expiry Output

This block is a programmable timeout timer advanced by a 1 kHz tick enable. Software configures it through one 8-bit control register that holds an enable flag and a 2-bit timeout selector. Every write to that register restarts the count. An external active-low rearm input restarts it as well, for as long as the input is held low. The rearm input is asynchronous and passes through a two-flop synchronizer before it is used.

When the selected number of ticks has elapsed without a restart, the active-low expiry output goes low. It stays low through later writes and rearm pulses. Only clearing the enable flag releases it. The output models the logic level of an open-drain pad, so a released output reads as high. The tick generator and the pad driver sit outside the block.

Top module: `wdt_timer`

## Requirements
- R1: After synchronous reset, the control register reads 0x00 and `expire_n` is 1.
- R2: A register write takes effect at the clock edge. From then on, `rd_data` bit 7 shows the enable, bits 1:0 show the timeout selector, and bits 6:2 read as zero.
- R3: Selector codes 0, 1, 2 and 3 select periods of P0, P1, P2 and P3 ticks (defaults 100, 200, 500 and 1000). With the timer enabled, `expire_n` falls at the clock edge of the period-th tick after the last restart, and it is still 1 after one tick fewer.
- R4: The count changes only in cycles with `tick` high. Cycles without a tick never cause expiry.
- R5: A write to the control register while the timer is running restarts the full period of the newly written selector.
- R6: While the synchronized `rearm_n` is 0, the count holds its reload value and the timer cannot expire. The synchronizer adds two cycles of latency on both edges of `rearm_n`.
- R7: Once `expire_n` is 0, it stays 0 while the enable bit is 1, including through writes that keep the enable set and through `rearm_n` pulses.
- R8: While the enable bit is 0, the count is held and no tick causes expiry. After a write that clears the enable, `expire_n` is 1 by the second clock edge.
- R9: If a restart and the final tick arrive in the same cycle, the restart wins: no expiry occurs, and a full new period begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | 1 kHz time-base enable, one clock wide |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Write data (bit 7 enable, bits 1:0 selector) |
| rd_data | output | 8 | Control register read value |
| rearm_n | input | 1 | Asynchronous active-low restart input |
| expire_n | output | 1 | Active-low sticky expiry output |

## Verification
The collision that matters is a restart and the expiring tick landing in the same cycle. The bench runs a count down to its final tick. It then applies that tick in the same cycle as a register write that keeps the timer enabled. The run is judged correct if `expire_n` stays high and a complete new period is needed before expiry. A second collision is a restart arriving after expiry. The bench issues such a write and a rearm pulse, and judges that the output remains latched low.

// File: rtl/wdt_pkg.sv
// Package: shared field positions and the configuration type of the
// watchdog timer. Assumes an 8-bit control register.
package wdt_pkg;

    localparam int REG_W   = 8;
    localparam int EN_POS  = 7;
    localparam int SEL_W   = 2;
    localparam int NUM_SEL = 1 << SEL_W;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
    } wdt_cfg_t;

endpackage

// File: rtl/wdt_cfg_reg.sv
// Control register: captures the enable flag and the timeout selector on a
// write strobe and builds the read value, with unused bits read as zero.
// Assumes a single-cycle write strobe in the clk domain.
module wdt_cfg_reg
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    output wdt_cfg_t         cfg,
    output logic [REG_W-1:0] rd_data
);

    // Hold the configuration fields; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr) begin
            cfg.en  <= wr_en;
            cfg.sel <= wr_sel;
        end
    end

    // Build the read value from the stored fields.
    always_comb begin
        rd_data             = '0;
        rd_data[EN_POS]     = cfg.en;
        rd_data[SEL_W-1:0]  = cfg.sel;
    end

endmodule

// File: rtl/wdt_sync.sv
// Synchronizer chain for an asynchronous level input. Resets to the
// inactive (high) level. Assumes STAGES >= 2.
module wdt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                // Pass the level one stage further.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/wdt_downcount.sv
// Tick-driven down-counter. A restart loads the period of the selector it
// is given. A tick that takes the count from 1 to 0 with no restart pending
// raises a one-cycle expiry pulse. Assumes every period is at least 1.
module wdt_downcount
    import wdt_pkg::*;
#(
    parameter int P0 = 100,
    parameter int P1 = 200,
    parameter int P2 = 500,
    parameter int P3 = 1000,
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic             running,
    input  logic [SEL_W-1:0] load_sel,
    output logic             expire
);

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] load_val;

    // Map the selector to its period in ticks.
    always_comb begin
        unique case (load_sel)
            2'd0:    load_val = CNT_W'(P0);
            2'd1:    load_val = CNT_W'(P1);
            2'd2:    load_val = CNT_W'(P2);
            default: load_val = CNT_W'(P3);
        endcase
    end

    // Load on a restart, otherwise step down once per tick until zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= CNT_W'(P0);
        end else if (restart) begin
            count <= load_val;
        end else if (tick && count != '0) begin
            count <= count - 1'b1;
        end
    end

    // Flag the tick that empties the counter; a restart masks it.
    assign expire = running && tick && !restart && (count == CNT_W'(1));

endmodule

// File: rtl/wdt_latch.sv
// Sticky expiry latch: set by an expiry pulse and cleared only while the
// timer is disabled. Assumes set and disabled are never both true.
module wdt_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic enabled,
    output logic fired
);

    // Remember expiry until the enable flag is cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)        fired <= 1'b0;
        else if (!enabled) fired <= 1'b0;
        else if (set)      fired <= 1'b1;
    end

endmodule

// File: rtl/wdt_timer.sv
// Retriggerable watchdog timer top. It ties together the control register,
// the rearm synchronizer, the down-counter and the sticky output latch.
// Assumes tick is a one-cycle enable in the clk domain and rearm_n is
// asynchronous.
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int P0 = 100,
    parameter int P1 = 200,
    parameter int P2 = 500,
    parameter int P3 = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] rd_data,
    input  logic             rearm_n,
    output logic             expire_n
);

    localparam int PMAX01 = (P0 > P1) ? P0 : P1;
    localparam int PMAX23 = (P2 > P3) ? P2 : P3;
    localparam int PMAX   = (PMAX01 > PMAX23) ? PMAX01 : PMAX23;
    localparam int CNT_W  = $clog2(PMAX + 1);

    wdt_cfg_t         cfg;
    logic             rearm_sync_n;
    logic             restart;
    logic [SEL_W-1:0] next_sel;
    logic             expire_pulse;
    logic             fired;

    wdt_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .wr_en   (reg_wdata[EN_POS]),
        .wr_sel  (reg_wdata[SEL_W-1:0]),
        .cfg     (cfg),
        .rd_data (rd_data)
    );

    wdt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (rearm_n),
        .sync_out (rearm_sync_n)
    );

    // Restart on a write, on a synchronized rearm, or while disabled.
    assign restart  = reg_wr || !rearm_sync_n || !cfg.en;
    assign next_sel = reg_wr ? reg_wdata[SEL_W-1:0] : cfg.sel;

    wdt_downcount #(
        .P0(P0), .P1(P1), .P2(P2), .P3(P3), .CNT_W(CNT_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .restart  (restart),
        .running  (cfg.en),
        .load_sel (next_sel),
        .expire   (expire_pulse)
    );

    wdt_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (expire_pulse),
        .enabled (cfg.en),
        .fired   (fired)
    );

    assign expire_n = !fired;

endmodule

// File: rtl/wdt_timer_chk.sv
// Assertion checker for wdt_timer, attached with a bind statement.
module wdt_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] rd_data,
    input logic       expire_n
);

    AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> rd_data == {$past(reg_wdata[7]), 5'b0, $past(reg_wdata[1:0])}); // R2

    AST_NO_TICK_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_n && !tick) |=> expire_n); // R4

    AST_STICKY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!expire_n && rd_data[7]) |=> !expire_n); // R7

    AST_DISABLED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[7] |=> expire_n); // R8

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_n && reg_wr) |=> expire_n); // R9

endmodule

bind wdt_timer wdt_timer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .rd_data   (rd_data),
    .expire_n  (expire_n)
);

// File: tb/wdt_timer_test.sv
// Self-checking bench for wdt_timer with small periods.
module wdt_timer_test;

    localparam int PB [4] = '{3, 5, 8, 12};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] rd_data;
    logic       rearm_n = 1'b1;
    logic       expire_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    wdt_timer #(.P0(PB[0]), .P1(PB[1]), .P2(PB[2]), .P3(PB[3])) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .rd_data(rd_data), .rearm_n(rearm_n),
        .expire_n(expire_n)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock cycle with the given inputs, driven and released at negedges.
    task automatic cyc(input logic t, input logic w, input logic [7:0] d);
        tick = t; reg_wr = w; reg_wdata = d;
        @(negedge clk);
        tick = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    endtask

    // A tick followed by an idle cycle.
    task automatic tk();
        cyc(1'b1, 1'b0, 8'h00);
        cyc(1'b0, 1'b0, 8'h00);
    endtask

    task automatic disable_timer(input string req);
        cyc(1'b0, 1'b1, 8'h00);
        cyc(1'b0, 1'b0, 8'h00);
        chk(req, {7'b0, expire_n}, 8'h01);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 rd", rd_data, 8'h00);
        chk("R1 out", {7'b0, expire_n}, 8'h01);

        // R2: every write value reads back masked
        for (int v = 0; v < 256; v++) begin
            cyc(1'b0, 1'b1, 8'(v));
            chk("R2", rd_data, 8'(v) & 8'h83);
        end
        cyc(1'b0, 1'b1, 8'h00);

        // R3/R4: each selector expires on exactly its period-th tick
        for (int s = 0; s < 4; s++) begin
            cyc(1'b0, 1'b1, 8'h80 | 8'(s));
            for (int k = 1; k <= PB[s]; k++) begin
                cyc(1'b1, 1'b0, 8'h00);
                repeat (2) cyc(1'b0, 1'b0, 8'h00);
                chk("R3 period", {7'b0, expire_n}, (k == PB[s]) ? 8'h00 : 8'h01);
            end
            disable_timer("R8 release");
        end

        // R5: a mid-count write restarts the full period
        cyc(1'b0, 1'b1, 8'h81);
        repeat (3) tk();
        cyc(1'b0, 1'b1, 8'h81);
        for (int k = 1; k <= PB[1]; k++) begin
            tk();
            chk("R5 restart", {7'b0, expire_n}, (k == PB[1]) ? 8'h00 : 8'h01);
        end

        // R7: expiry is sticky across a write and a rearm pulse
        cyc(1'b0, 1'b1, 8'h80);
        cyc(1'b0, 1'b0, 8'h00);
        chk("R7 write", {7'b0, expire_n}, 8'h00);
        rearm_n = 1'b0;
        repeat (4) tk();
        rearm_n = 1'b1;
        repeat (3) cyc(1'b0, 1'b0, 8'h00);
        chk("R7 rearm", {7'b0, expire_n}, 8'h00);
        disable_timer("R8 release");

        // R6: synchronized rearm low holds the count
        cyc(1'b0, 1'b1, 8'h80);
        rearm_n = 1'b0;
        repeat (3) cyc(1'b0, 1'b0, 8'h00);
        for (int k = 0; k < 10; k++) begin
            tk();
            chk("R6 held", {7'b0, expire_n}, 8'h01);
        end
        rearm_n = 1'b1;
        repeat (3) cyc(1'b0, 1'b0, 8'h00);
        for (int k = 1; k <= PB[0]; k++) begin
            tk();
            chk("R6 release", {7'b0, expire_n}, (k == PB[0]) ? 8'h00 : 8'h01);
        end
        disable_timer("R8 release");

        // R8: disabled timer ignores ticks
        cyc(1'b0, 1'b1, 8'h00);
        for (int k = 0; k < 20; k++) tk();
        chk("R8 disabled", {7'b0, expire_n}, 8'h01);

        // R9: write coincident with the final tick wins
        cyc(1'b0, 1'b1, 8'h80);
        for (int k = 1; k < PB[0]; k++) tk();
        cyc(1'b1, 1'b1, 8'h80);
        cyc(1'b0, 1'b0, 8'h00);
        chk("R9 collide", {7'b0, expire_n}, 8'h01);
        for (int k = 1; k <= PB[0]; k++) begin
            tk();
            chk("R9 new period", {7'b0, expire_n}, (k == PB[0]) ? 8'h00 : 8'h01);
        end
        disable_timer("R8 release");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule